// File: doc/BRIEF.md
# Serial ADC Sample Reader

This block is a serial host that collects one conversion result from a serial-output analog-to-digital converter each time a one-cycle sampling pulse arrives. When the pulse comes in and the block is idle, it pulls the active-low chip select down and runs a serial clock. That clock is made from the fast system clock by a divider that software can set while the chip runs. The block reads the data line on each rising serial-clock edge. It drops the leading blank bits, keeps the 14 data bits that follow, most significant first, and then releases the converter.

The converter changes its data line just after each falling serial-clock edge. The host samples on the next rising edge, a full half period later. When the frame is complete, the result appears on a parallel output together with a one-cycle valid strobe. The output keeps that value until the next frame finishes. While a frame is running, further sampling pulses are ignored.

Top module: `adc_sample_reader`

## Requirements
- R1: While `rst` is high, at each rising clock edge the block goes idle: `cs_n` = 1, `sclk` = 1, `sample_out` = 0, `sample_valid` = 0.
- R2: During a frame every serial-clock level lasts exactly N system-clock cycles, where N is the latched `div_ratio`, so the serial clock runs at the system rate divided by 2N.
- R3: A `div_ratio` of 0 behaves exactly like a value of 1.
- R4: A sampling pulse seen while idle drives `cs_n` low at the next edge. `sclk` stays high for N cycles before its first fall, and `sclk` is high whenever `cs_n` is high.
- R5: The data line is sampled on rising serial-clock edges. The first BLANK_BITS samples (default 1) are discarded. The next 14 samples form `sample_out` with the first of them in bit 13.
- R6: Each frame has exactly BLANK_BITS+14 falling and BLANK_BITS+14 rising serial-clock edges, so bits the converter would send after the data are never clocked.
- R7: On the edge that captures the last data bit, `cs_n` returns high and `sample_valid` is high for one cycle. This happens 2·N·(BLANK_BITS+14) cycles after the edge that accepted the pulse.
- R8: A sampling pulse that arrives while `cs_n` is low starts no frame and produces no extra valid strobe.
- R9: `sample_out` changes only in the cycle where `sample_valid` is high, and holds its value between frames.
- R10: `div_ratio` is latched when a frame starts. Changing it during the frame has no effect on that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_pulse | input | 1 | One-cycle request to read a conversion |
| div_ratio | input | 16 | Half-period length of the serial clock in system cycles (0 acts as 1) |
| sdo | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low chip select |
| sample_out | output | 14 | Last captured conversion result |
| sample_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
Frames are read with divider values 0, 1, 2, 3 and 5. This separates a correct half-period count from an off-by-one and shows whether zero is clamped. The sample words are all-ones, all-zeros, alternating patterns and arbitrary values, which exposes bit reversal, lost end bits and a blank bit that leaks into the result. The converter model drives its blank bit as one, so a host that keeps it is caught. One frame gets a stray pulse in the middle, and another gets a divider change in the middle. These separate a block that ignores both from one that restarts or retimes the frame.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_LEAD  = 2'd1,
        RD_SHIFT = 2'd2
    } rd_state_e;

endpackage

// File: rtl/adc_rd_tick_gen.sv
module adc_rd_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_ratio,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] lim;
        logic [DIV_W-1:0] cnt;
    } tick_reg_t;

    tick_reg_t r_q, r_d;
    logic      at_end;

    assign at_end = (r_q.cnt == r_q.lim - DIV_W'(1));
    assign tick   = run && at_end;

    always_comb begin
        r_d = r_q;
        if (!run) begin
            // latch the ratio while idle, clamping zero to one
            r_d.lim = (div_ratio == '0) ? DIV_W'(1) : div_ratio;
            r_d.cnt = '0;
        end else if (at_end) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.lim <= DIV_W'(1);
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         sdi,
    output logic [W-1:0] word_next
);

    logic [W-1:0] sr_q, sr_d;

    generate
        if (W == 1) begin : g_single
            assign word_next = sdi;
        end else begin : g_multi
            assign word_next = {sr_q[W-2:0], sdi};
        end
    endgenerate

    always_comb begin
        sr_d = sr_q;
        if (shift_en) begin
            sr_d = word_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

endmodule

// File: rtl/adc_sample_reader.sv
module adc_sample_reader
    import adc_rd_pkg::*;
#(
    parameter int DATA_W     = 14,
    parameter int BLANK_BITS = 1,
    parameter int DIV_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_pulse,
    input  logic [DIV_W-1:0]  div_ratio,
    input  logic              sdo,
    output logic              sclk,
    output logic              cs_n,
    output logic [DATA_W-1:0] sample_out,
    output logic              sample_valid
);

    localparam int FRAME_W = BLANK_BITS + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        rd_state_e         st;
        logic              cs_n;
        logic              sclk;
        logic [CNT_W-1:0]  rises;
        logic              valid;
        logic [DATA_W-1:0] dout;
    } rd_reg_t;

    rd_reg_t           r_q, r_d;
    logic              tick;
    logic              run;
    logic              shift_en;
    logic [DATA_W-1:0] word_next;

    assign run = (r_q.st != RD_IDLE);

    adc_rd_tick_gen #(
        .DIV_W(DIV_W)
    ) u_tick (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .div_ratio(div_ratio),
        .tick     (tick)
    );

    adc_rd_shifter #(
        .W(DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .sdi      (sdo),
        .word_next(word_next)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        shift_en  = 1'b0;
        unique case (r_q.st)
            RD_IDLE: begin
                if (sample_pulse) begin
                    r_d.st    = RD_LEAD;
                    r_d.cs_n  = 1'b0;
                    r_d.rises = '0;
                end
            end
            RD_LEAD: begin
                // one half period with select low and clock high
                if (tick) begin
                    r_d.sclk = 1'b0;
                    r_d.st   = RD_SHIFT;
                end
            end
            RD_SHIFT: begin
                if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk = 1'b1;
                        shift_en = 1'b1;
                        if (r_q.rises == CNT_W'(FRAME_W - 1)) begin
                            r_d.st    = RD_IDLE;
                            r_d.cs_n  = 1'b1;
                            r_d.valid = 1'b1;
                            r_d.dout  = word_next;
                        end else begin
                            r_d.rises = r_q.rises + CNT_W'(1);
                        end
                    end else begin
                        r_d.sclk = 1'b0;
                    end
                end
            end
            default: begin
                r_d.st   = RD_IDLE;
                r_d.cs_n = 1'b1;
                r_d.sclk = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st    <= RD_IDLE;
            r_q.cs_n  <= 1'b1;
            r_q.sclk  <= 1'b1;
            r_q.rises <= '0;
            r_q.valid <= 1'b0;
            r_q.dout  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk         = r_q.sclk;
    assign cs_n         = r_q.cs_n;
    assign sample_out   = r_q.dout;
    assign sample_valid = r_q.valid;

endmodule

// File: rtl/adc_sample_reader_chk.sv
module adc_sample_reader_chk #(
    parameter int DATA_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              sample_pulse,
    input logic              sclk,
    input logic              cs_n,
    input logic [DATA_W-1:0] sample_out,
    input logic              sample_valid
);

    // R4: the serial clock rests high whenever the converter is deselected
    p_sclk_high_idle_r4: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    // R4: select only drops in answer to a pulse
    p_cs_fall_needs_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $past(sample_pulse));

    // R6: no serial clock edges between frames
    p_sclk_still_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> $stable(sclk));

    // R7: the strobe lasts a single cycle
    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    // R7: release of select and the strobe coincide
    p_valid_with_release_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> sample_valid);

    // R8: with select low, nothing starts or ends without the frame ending
    p_no_valid_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> cs_n);

    // R9: the result only moves with the strobe
    p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sample_out) |-> sample_valid);

endmodule

bind adc_sample_reader adc_sample_reader_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sample_pulse(sample_pulse),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .sample_out  (sample_out),
    .sample_valid(sample_valid)
);

// File: tb/adc_sample_reader_bench.sv
module adc_sample_reader_bench;

    localparam int DATA_W  = 14;
    localparam int BLANK   = 1;
    localparam int FRAME_W = BLANK + DATA_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sample_pulse = 1'b0;
    logic [15:0]       div_ratio = 16'd2;
    logic              sdo = 1'b1;
    logic              sclk;
    logic              cs_n;
    logic [DATA_W-1:0] sample_out;
    logic              sample_valid;

    adc_sample_reader u_adc_sample_reader (
        .clk         (clk),
        .rst         (rst),
        .sample_pulse(sample_pulse),
        .div_ratio   (div_ratio),
        .sdo         (sdo),
        .sclk        (sclk),
        .cs_n        (cs_n),
        .sample_out  (sample_out),
        .sample_valid(sample_valid)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [DATA_W-1:0] data;
        int                start;
        int                n;
        string             tag;
    } exp_t;

    exp_t              sb_q[$];
    int                n_cmp = 0;
    int                n_bad = 0;
    int                cyc = 0;
    logic [DATA_W-1:0] adc_word = '0;
    int                pos = FRAME_W - 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            finish_run();
        end
    end

    // converter model: blank bits driven as one, then data MSB first, then zeros
    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            pos = FRAME_W - 1;
        end else begin
            if (pos > DATA_W - 1) sdo = 1'b1;
            else if (pos < 0)     sdo = 1'b0;
            else                  sdo = adc_word[pos];
            pos = pos - 1;
        end
    end

    // monitor
    logic sclk_prev = 1'b1;
    logic cs_prev   = 1'b1;
    int   gap = 0, falls = 0, rises = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cs_prev && !cs_n) begin
                gap = 0; falls = 0; rises = 0;
            end else if (!cs_prev) begin
                gap++;
                if (sclk != sclk_prev) begin
                    if (sb_q.size() > 0)
                        check(gap == sb_q[0].n, "R2 R4", "half period cycles", gap, sb_q[0].n);
                    gap = 0;
                    if (sclk) rises++; else falls++;
                end
                if (cs_n) begin
                    check(rises == FRAME_W, "R6", "rising edges", rises, FRAME_W);
                    check(falls == FRAME_W, "R6", "falling edges", falls, FRAME_W);
                end
            end
            if (sample_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(sample_out == e.data, "R5", "sample", int'(sample_out), int'(e.data));
                    check(cyc - e.start == 2 * e.n * FRAME_W, e.tag, "latency",
                          cyc - e.start, 2 * e.n * FRAME_W);
                    check(cs_n == 1'b1, "R7", "cs_n at valid", int'(cs_n), 1);
                end
            end
        end
        sclk_prev = sclk;
        cs_prev   = cs_n;
    end

    task automatic run_frame(input logic [DATA_W-1:0] word, input int div,
                             input int stray_at, input int newdiv_at, input string tag);
        exp_t e;
        int   n;
        n = (div == 0) ? 1 : div;
        @(negedge clk);
        adc_word     = word;
        div_ratio    = 16'(div);
        sample_pulse = 1'b1;
        @(negedge clk);
        sample_pulse = 1'b0;
        e.data  = word;
        e.start = cyc;
        e.n     = n;
        e.tag   = tag;
        sb_q.push_back(e);
        check(cs_n == 1'b0, "R4", "cs_n after pulse", int'(cs_n), 0);
        for (int k = 0; k < 2 * n * FRAME_W + 6; k++) begin
            if (k == stray_at) sample_pulse = 1'b1;
            if (k == newdiv_at) div_ratio = 16'(n + 2);
            @(negedge clk);
            sample_pulse = 1'b0;
        end
        check(sample_out == word, "R9", "held result", int'(sample_out), int'(word));
        check(cs_n == 1'b1, "R8", "idle after frame", int'(cs_n), 1);
        check(sb_q.size() == 0, "R8", "pending frames", sb_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
        check(sclk == 1'b1, "R1", "sclk in reset", int'(sclk), 1);
        check(sample_out == '0, "R1", "output in reset", int'(sample_out), 0);
        check(sample_valid == 1'b0, "R1", "valid in reset", int'(sample_valid), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        run_frame(14'd12345, 2, -1, -1, "R7");
        run_frame(14'd5782,  1, -1, -1, "R7");
        run_frame(14'd777,   0, -1, -1, "R3");
        run_frame(14'h3FFF,  3, -1, -1, "R7");
        run_frame(14'h0000,  5, -1, -1, "R7");
        run_frame(14'h2AAA,  2, 10, -1, "R8");
        run_frame(14'h1555,  2, -1, 7,  "R10");
        run_frame(14'h2001,  0, 4,  -1, "R3");
        repeat (10) @(negedge clk);
        check(sample_out == 14'h2001, "R9", "final hold", int'(sample_out), 14'h2001);
        finish_run();
    end

endmodule